// File: doc/BRIEF.md
# Buffered Asynchronous Serial Transceiver

This block is a full-duplex asynchronous serial port. A transmit engine and a receive engine run independently, and each one has a 64-entry FIFO in front of it. A host uses a small address/data/strobe register port to push bytes for transmission, pop received bytes, and read live fill levels, per-entry error information and status. The 16x oversampling tick comes from one of two sources: an internal divider of the system clock, or the rising edges of an external serial clock input.

Four interrupt lines report four conditions: transmit FIFO empty, break seen, receive level reached, and receive entries with errors. Each line has its own enable. Two DMA request levels follow the transmit-empty and receive-level conditions so that a DMA engine can refill or drain the FIFOs. Hardware flow control has two parts. The CTS input can hold off new frames, and the RTS output is raised when the receive FIFO fills to a programmable level. An idle-timeout flag tells the host that bytes are waiting in the receive FIFO while the line has gone quiet.

Top module: `suart_top`

## Requirements
- R1: After synchronous reset, txd_o and all interrupt and DMA outputs hold 1, 0 and 0 as stated below: txd_o is 1, every interrupt and DMA output is 0, and rts_n_o is 0. Both FIFO counts read 0, and the status register (address 4) reads 8'h01.
- R2: A transmitted frame has these parts in order: a start bit at 0, eight data bits with the LSB first, a parity bit if control bit 3 is set, and a stop bit at 1. Each bit lasts 16 ticks. Bytes written to address 0 are sent in write order, back to back.
- R3: The receiver confirms a start bit at its half-bit point and samples each following bit at mid-bit. A good frame is pushed to the receive FIFO. Reading address 0 with rd_en returns the oldest byte and pops it. Transmit and receive can run at the same time.
- R4: Each FIFO holds 64 entries, and a push to a full FIFO is dropped. Address 6 reads the transmit count and address 7 reads the receive count.
- R5: Control bit 3 enables parity and bit 4 selects odd parity, with even parity when bit 4 is 0. An entry received with a parity mismatch is marked as an error. Address 8 reads the number of error entries in the receive FIFO, and status bit 3 shows the error mark of the head entry.
- R6: A frame whose stop bit samples 0, and which is not a break, is stored with its error mark set.
- R7: A frame in which all data bits, the parity bit if enabled, and the stop bit are all 0 is a break. A break sets status bit 1 and does not push an entry. Writing 1 to status bit 1 clears it.
- R8: When control bit 5 (flow control) is set and cts_n_i is high, no new frame starts. Queued bytes leave once cts_n_i falls.
- R9: When flow control is on, rts_n_o goes high one clock after the receive count reaches the threshold at address 5 (reset value 48). It goes low again once the count falls below that threshold.
- R10: Status bit 4 (timeout) sets after 15 bit times of idle receive line while the receive FIFO is not empty. A pop clears it.
- R11: The interrupt enables are at address 3. Bit 0 gates irq_txe_o (transmit FIFO empty), bit 1 gates irq_brk_o (break flag), bit 2 gates irq_rxf_o (receive count at or above the threshold) and bit 3 gates irq_err_o (error count not 0).
- R12: dma_tx_req_o is high when the transmitter is enabled (control bit 0) and its FIFO is empty. dma_rx_req_o is high when the receiver is enabled (control bit 1) and the receive count is at or above the threshold.
- R13: When control bit 2 is 0, a tick occurs every DIV+1 clocks, where DIV is at address 2. When control bit 2 is 1, each rising edge of ext_clk_i is one tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 4 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Read strobe; pops the receive FIFO at address 0 |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| ext_clk_i | input | 1 | External 16x serial clock |
| rxd_i | input | 1 | Serial receive line |
| txd_o | output | 1 | Serial transmit line |
| cts_n_i | input | 1 | Clear to send, active low |
| rts_n_o | output | 1 | Request to send, active low |
| irq_txe_o | output | 1 | Transmit FIFO empty interrupt |
| irq_brk_o | output | 1 | Break interrupt |
| irq_rxf_o | output | 1 | Receive level interrupt |
| irq_err_o | output | 1 | Receive error interrupt |
| dma_tx_req_o | output | 1 | Transmit DMA request |
| dma_rx_req_o | output | 1 | Receive DMA request |

## Verification
The hardest states to reach from the ports are the two FIFO-full boundaries. At each one, a 65th byte must vanish while the 64 bytes before it stay intact and in order. To hold the transmit side full, the bench disables the transmitter, writes 70 bytes, and then drains and compares all 64 frames. To fill the receive side, the bench sends 66 frames before popping anything. Break, framing and parity errors are produced by driving the receive line bit by bit with a deliberately wrong stop or parity value. The timeout is checked on both sides of its 15-bit window.

// File: rtl/suart_pkg.sv
package suart_pkg;
    localparam int DW = 8;

    typedef enum logic [2:0] {
        S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRKW
    } ser_state_e;

    // control register: bit0 tx_en .. bit5 flow_en
    typedef struct packed {
        logic flow_en;
        logic par_odd;
        logic par_en;
        logic clk_ext;
        logic rx_en;
        logic tx_en;
    } ctrl_t;

    typedef struct packed {
        logic          err;
        logic [DW-1:0] data;
    } rx_entry_t;

    localparam logic [3:0] A_DATA   = 4'd0;
    localparam logic [3:0] A_CTRL   = 4'd1;
    localparam logic [3:0] A_DIV    = 4'd2;
    localparam logic [3:0] A_IEN    = 4'd3;
    localparam logic [3:0] A_STAT   = 4'd4;
    localparam logic [3:0] A_THR    = 4'd5;
    localparam logic [3:0] A_TXCNT  = 4'd6;
    localparam logic [3:0] A_RXCNT  = 4'd7;
    localparam logic [3:0] A_ERRCNT = 4'd8;

    function automatic logic par_bit(input logic [DW-1:0] d, input logic odd);
        return (^d) ^ odd;
    endfunction
endpackage

// File: rtl/suart_fifo.sv
module suart_fifo #(
    parameter int W     = 8,
    parameter int DEPTH = 64    // power of two
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         push,
    input  logic [W-1:0]                 wdata,
    input  logic                         pop,
    output logic [W-1:0]                 rdata,
    output logic [$clog2(DEPTH+1)-1:0]   count,
    output logic                         full,
    output logic                         empty
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = $clog2(DEPTH+1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rp];

    always_ff @(posedge clk) begin
        if (do_push) mem[wp] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= wp + 1'b1;
            if (do_pop)  rp <= rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    // R4: a push into a full FIFO leaves the level unchanged
    a_r4_full_drop: assert property (@(posedge clk) disable iff (rst)
        (push && full && !pop) |=> (count == $past(count)));
    a_r4_no_underflow: assert property (@(posedge clk) disable iff (rst)
        (pop && empty && !push) |=> (count == '0));
endmodule

// File: rtl/suart_tick.sv
module suart_tick #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [DIVW-1:0] div,
    input  logic            use_ext,
    input  logic            ext_clk,
    output logic            tick
);
    logic [2:0]      es;
    logic [DIVW-1:0] cnt;
    logic            int_hit;

    assign int_hit = (cnt == div);
    assign tick    = use_ext ? (es[1] && !es[2]) : int_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            es  <= '0;
            cnt <= '0;
        end else begin
            es <= {es[1:0], ext_clk};
            if (use_ext || int_hit) cnt <= '0;
            else                    cnt <= cnt + 1'b1;
        end
    end

    // R13: with a nonzero divisor internal ticks are never adjacent
    a_r13_tick_spacing: assert property (@(posedge clk) disable iff (rst)
        (tick && !use_ext && div != '0) |=> (!tick || use_ext || div == '0));
endmodule

// File: rtl/suart_tx.sv
module suart_tx
    import suart_pkg::*;
#(
    parameter int OVS = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          tick,
    input  logic          en,
    input  logic          par_en,
    input  logic          par_odd,
    input  logic          flow_en,
    input  logic          cts_n,
    input  logic          have_data,
    input  logic [DW-1:0] data,
    output logic          pop,
    output logic          txd,
    output logic          busy
);
    localparam int SW = $clog2(OVS);

    ser_state_e    st;
    logic [SW-1:0] sub;
    logic [2:0]    bitn;
    logic [DW-1:0] sh;
    logic          pb;
    logic [1:0]    cts_s;
    logic          last, hold;

    assign hold = flow_en && cts_s[1];
    assign pop  = (st == S_IDLE) && tick && en && have_data && !hold;
    assign last = tick && (sub == SW'(OVS-1));
    assign busy = (st != S_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            st    <= S_IDLE;
            sub   <= '0;
            bitn  <= '0;
            sh    <= '0;
            pb    <= 1'b0;
            txd   <= 1'b1;
            cts_s <= 2'b11;
        end else begin
            cts_s <= {cts_s[0], cts_n};
            if (st != S_IDLE && tick) sub <= last ? '0 : sub + 1'b1;
            case (st)
                S_IDLE: if (pop) begin
                    sh  <= data;
                    pb  <= par_bit(data, par_odd);
                    txd <= 1'b0;
                    sub <= '0;
                    st  <= S_START;
                end
                S_START: if (last) begin
                    txd  <= sh[0];
                    bitn <= '0;
                    st   <= S_DATA;
                end
                S_DATA: if (last) begin
                    sh <= sh >> 1;
                    if (bitn == 3'(DW-1)) begin
                        if (par_en) begin
                            txd <= pb;
                            st  <= S_PAR;
                        end else begin
                            txd <= 1'b1;
                            st  <= S_STOP;
                        end
                    end else begin
                        txd  <= sh[1];
                        bitn <= bitn + 1'b1;
                    end
                end
                S_PAR: if (last) begin
                    txd <= 1'b1;
                    st  <= S_STOP;
                end
                S_STOP: if (last) st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    // R8: a held-off transmitter stays idle
    a_r8_cts_hold: assert property (@(posedge clk) disable iff (rst)
        (st == S_IDLE && flow_en && cts_s[1]) |=> (st == S_IDLE));
    a_r2_start_low: assert property (@(posedge clk) disable iff (rst)
        (st == S_START) |-> !txd);
    a_r2_stop_high: assert property (@(posedge clk) disable iff (rst)
        (st == S_STOP) |-> txd);
endmodule

// File: rtl/suart_rx.sv
module suart_rx
    import suart_pkg::*;
#(
    parameter int OVS    = 16,
    parameter int TO_ETU = 15
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      tick,
    input  logic      en,
    input  logic      rxd,
    input  logic      par_en,
    input  logic      par_odd,
    input  logic      fifo_empty,
    input  logic      host_pop,
    output logic      push,
    output rx_entry_t entry,
    output logic      brk_set,
    output logic      timeout
);
    localparam int SW       = $clog2(OVS);
    localparam int TO_TICKS = TO_ETU * OVS;
    localparam int TW       = $clog2(TO_TICKS + 1);

    ser_state_e    st;
    logic [SW-1:0] sub;
    logic [2:0]    bitn;
    logic [DW-1:0] sh;
    logic          pb;
    logic [1:0]    rs;
    logic          line, last;
    logic [TW-1:0] tcnt;

    assign line = rs[1];
    assign last = tick && (sub == SW'(OVS-1));

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            sub     <= '0;
            bitn    <= '0;
            sh      <= '0;
            pb      <= 1'b0;
            rs      <= 2'b11;
            push    <= 1'b0;
            brk_set <= 1'b0;
            entry   <= '0;
        end else begin
            rs      <= {rs[0], rxd};
            push    <= 1'b0;
            brk_set <= 1'b0;
            if (st != S_IDLE && st != S_BRKW && tick) sub <= last ? '0 : sub + 1'b1;
            case (st)
                S_IDLE: if (tick && en && !line) begin
                    sub <= '0;
                    st  <= S_START;
                end
                S_START: if (tick && sub == SW'(OVS/2-1)) begin
                    sub  <= '0;
                    bitn <= '0;
                    st   <= line ? S_IDLE : S_DATA;
                end
                S_DATA: if (last) begin
                    sh   <= {line, sh[DW-1:1]};
                    bitn <= bitn + 1'b1;
                    if (bitn == 3'(DW-1)) st <= par_en ? S_PAR : S_STOP;
                end
                S_PAR: if (last) begin
                    pb <= line;
                    st <= S_STOP;
                end
                S_STOP: if (last) begin
                    if (sh == '0 && !line && !(par_en && pb)) begin
                        brk_set <= 1'b1;
                        st      <= S_BRKW;
                    end else begin
                        push       <= 1'b1;
                        entry.data <= sh;
                        entry.err  <= !line || (par_en && (pb != par_bit(sh, par_odd)));
                        st         <= S_IDLE;
                    end
                end
                S_BRKW: if (line) st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst || host_pop) begin
            tcnt    <= '0;
            timeout <= 1'b0;
        end else if (st != S_IDLE || fifo_empty) begin
            tcnt <= '0;
        end else if (tick && !timeout) begin
            if (tcnt == TW'(TO_TICKS-1)) begin
                timeout <= 1'b1;
                tcnt    <= '0;
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    // R10: timeout only rises with data waiting
    a_r10_to_needs_data: assert property (@(posedge clk) disable iff (rst)
        $rose(timeout) |-> !fifo_empty);
    // R7: after a break the receiver waits for the line to return high
    a_r7_brk_wait: assert property (@(posedge clk) disable iff (rst)
        (st == S_BRKW && !line) |=> (st == S_BRKW));
    a_r7_brk_no_push: assert property (@(posedge clk) disable iff (rst)
        brk_set |-> !push);
endmodule

// File: rtl/suart_top.sv
module suart_top
    import suart_pkg::*;
#(
    parameter int DEPTH   = 64,
    parameter int DIVW    = 8,
    parameter int OVS     = 16,
    parameter int TO_ETU  = 15,
    parameter int THR_RST = 48
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] addr,
    input  logic       wr_en,
    input  logic       rd_en,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    input  logic       ext_clk_i,
    input  logic       rxd_i,
    output logic       txd_o,
    input  logic       cts_n_i,
    output logic       rts_n_o,
    output logic       irq_txe_o,
    output logic       irq_brk_o,
    output logic       irq_rxf_o,
    output logic       irq_err_o,
    output logic       dma_tx_req_o,
    output logic       dma_rx_req_o
);
    localparam int CW = $clog2(DEPTH + 1);
    localparam int EW = $bits(rx_entry_t);

    ctrl_t          ctrl;
    logic [DIVW-1:0] div;
    logic [3:0]     ien;
    logic [CW-1:0]  thr;
    logic           brk_flag;
    logic [CW-1:0]  errcnt;

    logic           tick;
    logic           tx_push, tx_pop, tx_full, tx_empty, tx_busy;
    logic [DW-1:0]  tx_head;
    logic [CW-1:0]  tx_cnt;

    logic           rx_push, rx_pop, rx_full, rx_empty;
    rx_entry_t      rx_in, rx_head;
    logic [EW-1:0]  rx_raw;
    logic [CW-1:0]  rx_cnt;
    logic           brk_set, timeout, rx_lvl;

    assign tx_push = wr_en && addr == A_DATA;
    assign rx_pop  = rd_en && addr == A_DATA;
    assign rx_head = rx_entry_t'(rx_raw);
    assign rx_lvl  = (rx_cnt >= thr);

    suart_tick #(.DIVW(DIVW)) u_tick (
        .clk(clk), .rst(rst), .div(div), .use_ext(ctrl.clk_ext),
        .ext_clk(ext_clk_i), .tick(tick)
    );

    suart_fifo #(.W(DW), .DEPTH(DEPTH)) u_txf (
        .clk(clk), .rst(rst), .push(tx_push), .wdata(wdata), .pop(tx_pop),
        .rdata(tx_head), .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    suart_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst(rst), .tick(tick), .en(ctrl.tx_en), .par_en(ctrl.par_en),
        .par_odd(ctrl.par_odd), .flow_en(ctrl.flow_en), .cts_n(cts_n_i),
        .have_data(!tx_empty), .data(tx_head), .pop(tx_pop), .txd(txd_o), .busy(tx_busy)
    );

    suart_fifo #(.W(EW), .DEPTH(DEPTH)) u_rxf (
        .clk(clk), .rst(rst), .push(rx_push), .wdata(rx_in), .pop(rx_pop),
        .rdata(rx_raw), .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    suart_rx #(.OVS(OVS), .TO_ETU(TO_ETU)) u_rx (
        .clk(clk), .rst(rst), .tick(tick), .en(ctrl.rx_en), .rxd(rxd_i),
        .par_en(ctrl.par_en), .par_odd(ctrl.par_odd), .fifo_empty(rx_empty),
        .host_pop(rx_pop), .push(rx_push), .entry(rx_in), .brk_set(brk_set),
        .timeout(timeout)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl     <= '0;
            div      <= '0;
            ien      <= '0;
            thr      <= CW'(THR_RST);
            brk_flag <= 1'b0;
            errcnt   <= '0;
            rts_n_o  <= 1'b0;
        end else begin
            if (wr_en) begin
                case (addr)
                    A_CTRL: ctrl <= ctrl_t'(wdata[5:0]);
                    A_DIV:  div  <= wdata[DIVW-1:0];
                    A_IEN:  ien  <= wdata[3:0];
                    A_THR:  thr  <= wdata[CW-1:0];
                    A_STAT: if (wdata[1]) brk_flag <= 1'b0;
                    default: ;
                endcase
            end
            if (brk_set) brk_flag <= 1'b1;
            errcnt <= errcnt + CW'(rx_push && rx_in.err && !rx_full)
                             - CW'(rx_pop && !rx_empty && rx_head.err);
            rts_n_o <= ctrl.flow_en && rx_lvl;
        end
    end

    always_comb begin
        case (addr)
            A_DATA:   rdata = rx_empty ? '0 : rx_head.data;
            A_CTRL:   rdata = 8'(ctrl);
            A_DIV:    rdata = 8'(div);
            A_IEN:    rdata = 8'(ien);
            A_STAT:   rdata = {2'b00, tx_busy, timeout, rx_head.err && !rx_empty,
                               rx_lvl, brk_flag, tx_empty};
            A_THR:    rdata = 8'(thr);
            A_TXCNT:  rdata = 8'(tx_cnt);
            A_RXCNT:  rdata = 8'(rx_cnt);
            A_ERRCNT: rdata = 8'(errcnt);
            default:  rdata = '0;
        endcase
    end

    assign irq_txe_o    = ien[0] && tx_empty;
    assign irq_brk_o    = ien[1] && brk_flag;
    assign irq_rxf_o    = ien[2] && rx_lvl;
    assign irq_err_o    = ien[3] && (errcnt != '0);
    assign dma_tx_req_o = ctrl.tx_en && tx_empty;
    assign dma_rx_req_o = ctrl.rx_en && rx_lvl;

    // R5: the error count never exceeds the receive level
    a_r5_errcnt_bound: assert property (@(posedge clk) disable iff (rst)
        errcnt <= rx_cnt);
    // R9: RTS follows the receive level one clock later
    a_r9_rts_high: assert property (@(posedge clk) disable iff (rst)
        (ctrl.flow_en && rx_cnt >= thr) |=> rts_n_o);
endmodule

// File: tb/sim_suart_top.sv
module sim_suart_top;
    localparam int CLKP = 10;
    localparam int BIT  = 32;   // DIV=1: tick every 2 clocks, 16 ticks per bit
    localparam logic [3:0] R_DATA = 0, R_CTRL = 1, R_DIV = 2, R_IEN = 3, R_STAT = 4,
                           R_THR = 5, R_TXCNT = 6, R_RXCNT = 7, R_ERRCNT = 8;

    logic clk = 0;
    always #(CLKP/2) clk = ~clk;

    logic rst = 1, wr_en = 0, rd_en = 0, ext_clk = 0, rxd = 1, cts_n = 0;
    logic [3:0] addr = 0;
    logic [7:0] wdata = 0, rdata;
    logic txd, rts_n, irq_txe, irq_brk, irq_rxf, irq_err, dma_tx, dma_rx;
    bit ext_run = 0, done = 0;
    int checks = 0, errors = 0;
    byte unsigned tx_q[$];
    byte unsigned rx_q[$];

    suart_top u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
        .wdata(wdata), .rdata(rdata), .ext_clk_i(ext_clk), .rxd_i(rxd),
        .txd_o(txd), .cts_n_i(cts_n), .rts_n_o(rts_n), .irq_txe_o(irq_txe),
        .irq_brk_o(irq_brk), .irq_rxf_o(irq_rxf), .irq_err_o(irq_err),
        .dma_tx_req_o(dma_tx), .dma_rx_req_o(dma_rx)
    );

    initial forever begin
        repeat (2) @(negedge clk);
        if (ext_run) ext_clk = ~ext_clk;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr_en = 1;
        @(negedge clk); wr_en = 0;
        if (a == R_DATA) tx_q.push_back(d);
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; #1; d = rdata;
    endtask

    task automatic pop(output logic [7:0] d);
        @(negedge clk); addr = R_DATA; #1; d = rdata; rd_en = 1;
        @(negedge clk); rd_en = 0;
    endtask

    task automatic send(input logic [7:0] d, input bit usep, input bit pv,
                        input bit stopv, input int bt);
        @(negedge clk); rxd = 0; repeat (bt) @(negedge clk);
        for (int i = 0; i < 8; i++) begin rxd = d[i]; repeat (bt) @(negedge clk); end
        if (usep) begin rxd = pv; repeat (bt) @(negedge clk); end
        rxd = stopv;
        if (stopv) repeat (bt) @(negedge clk);
        else begin repeat (bt/2 + 4) @(negedge clk); rxd = 1; repeat (bt/2) @(negedge clk); end
        rxd = 1;
    endtask

    task automatic recv(input int bt, input bit usep, input string tag,
                        output logic [7:0] d, output logic pb);
        logic stp;
        byte unsigned e;
        @(negedge txd);
        repeat (bt/2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin repeat (bt) @(negedge clk); d[i] = txd; end
        pb = 0;
        if (usep) begin repeat (bt) @(negedge clk); pb = txd; end
        repeat (bt) @(negedge clk); stp = txd;
        e = (tx_q.size() > 0) ? tx_q.pop_front() : 8'hxx;
        chk({tag, " tx byte"}, d, e);
        chk({tag, " stop bit"}, stp, 1);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog (R1..R13 run) actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] v, d;
        logic pb;
        int bad;
        repeat (5) @(negedge clk);
        rst = 0;
        // R1 reset state
        @(negedge clk);
        chk("R1 txd idle", txd, 1);
        chk("R1 rts_n", rts_n, 0);
        chk("R1 irqs", {irq_txe, irq_brk, irq_rxf, irq_err}, 0);
        chk("R1 dma", {dma_tx, dma_rx}, 0);
        rd(R_TXCNT, v); chk("R1 tx count", v, 0);
        rd(R_RXCNT, v); chk("R1 rx count", v, 0);
        rd(R_STAT, v);  chk("R1 status", v, 8'h01);

        wr(R_DIV, 1);
        wr(R_CTRL, 8'h03);
        // R2 three bytes back to back, in order
        fork
            begin wr(R_DATA, 8'h5A); wr(R_DATA, 8'hC3); wr(R_DATA, 8'h01); end
            begin for (int k = 0; k < 3; k++) recv(BIT, 0, "R2", d, pb); end
        join

        // R3 full duplex: receive A5 while sending 3C
        fork
            begin send(8'hA5, 0, 0, 1, BIT); rx_q.push_back(8'hA5); end
            begin wr(R_DATA, 8'h3C); recv(BIT, 0, "R3", d, pb); end
        join
        repeat (4) @(negedge clk);
        rd(R_RXCNT, v); chk("R3 rx count", v, 1);
        pop(v); chk("R3 rx byte", v, rx_q.pop_front());

        // R5 even parity on both sides
        wr(R_CTRL, 8'h0B);
        fork
            wr(R_DATA, 8'h07);
            recv(BIT, 1, "R5", d, pb);
        join
        chk("R5 tx even parity bit", pb, 1);
        send(8'h07, 1, 0, 1, BIT);   // wrong parity
        send(8'h07, 1, 1, 1, BIT);   // right parity
        wr(R_IEN, 8'h08);
        repeat (4) @(negedge clk);
        rd(R_ERRCNT, v); chk("R5 error count", v, 1);
        rd(R_STAT, v);   chk("R5 head error bit", v[3], 1);
        chk("R11 irq_err raised", irq_err, 1);
        pop(v); chk("R5 bad entry data", v, 8'h07);
        rd(R_ERRCNT, v); chk("R5 error count after pop", v, 0);
        chk("R11 irq_err cleared", irq_err, 0);
        pop(v); chk("R5 good entry data", v, 8'h07);
        wr(R_CTRL, 8'h1B);           // odd parity
        send(8'h07, 1, 0, 1, BIT);
        repeat (4) @(negedge clk);
        rd(R_ERRCNT, v); chk("R5 odd parity accepted", v, 0);
        pop(v);

        // R6 framing error
        wr(R_CTRL, 8'h03);
        send(8'h81, 0, 0, 0, BIT);
        repeat (3*BIT) @(negedge clk);
        rd(R_RXCNT, v);  chk("R6 stored", v, 1);
        rd(R_ERRCNT, v); chk("R6 marked error", v, 1);
        pop(v); chk("R6 data", v, 8'h81);

        // R7 break
        wr(R_IEN, 8'h02);
        @(negedge clk); rxd = 0; repeat (11*BIT) @(negedge clk); rxd = 1;
        repeat (2*BIT) @(negedge clk);
        rd(R_STAT, v);  chk("R7 break flag", v[1], 1);
        chk("R11 irq_brk", irq_brk, 1);
        rd(R_RXCNT, v); chk("R7 no entry pushed", v, 0);
        wr(R_STAT, 8'h02);
        rd(R_STAT, v);  chk("R7 flag cleared", v[1], 0);
        chk("R7 irq_brk cleared", irq_brk, 0);

        // R4 transmit FIFO full
        wr(R_CTRL, 8'h02);
        for (int i = 0; i < 70; i++) begin
            @(negedge clk); addr = R_DATA; wdata = 8'(i); wr_en = 1;
            @(negedge clk); wr_en = 0;
            if (i < 64) tx_q.push_back(8'(i));
        end
        rd(R_TXCNT, v); chk("R4 tx count capped", v, 64);
        chk("R12 no tx dma while disabled", dma_tx, 0);
        wr(R_CTRL, 8'h03);
        for (int i = 0; i < 64; i++) recv(BIT, 0, "R4 drain", d, pb);
        repeat (BIT) @(negedge clk);
        rd(R_TXCNT, v); chk("R4 tx count drained", v, 0);
        wr(R_IEN, 8'h01);
        chk("R11 irq_txe", irq_txe, 1);
        chk("R12 dma_tx", dma_tx, 1);

        // R4 receive FIFO full
        for (int i = 0; i < 66; i++) send(8'(i), 0, 0, 1, BIT);
        repeat (4) @(negedge clk);
        rd(R_RXCNT, v); chk("R4 rx count capped", v, 64);
        bad = 0;
        for (int i = 0; i < 64; i++) begin pop(v); if (v != 8'(i)) bad++; end
        chk("R4 rx order kept, overflow dropped", bad, 0);

        // R9 R11 R12 receive level
        wr(R_THR, 2);
        wr(R_IEN, 8'h04);
        wr(R_CTRL, 8'h23);
        chk("R9 rts low below level", rts_n, 0);
        send(8'h11, 0, 0, 1, BIT);
        send(8'h22, 0, 0, 1, BIT);
        repeat (4) @(negedge clk);
        chk("R11 irq_rxf", irq_rxf, 1);
        chk("R12 dma_rx", dma_rx, 1);
        chk("R9 rts high at level", rts_n, 1);
        pop(v); chk("R9 first byte", v, 8'h11);
        repeat (2) @(negedge clk);
        chk("R9 rts low again", rts_n, 0);
        chk("R12 dma_rx dropped", dma_rx, 0);
        pop(v);

        // R10 timeout window
        send(8'h33, 0, 0, 1, BIT);
        repeat (300) @(negedge clk);
        rd(R_STAT, v); chk("R10 no timeout early", v[4], 0);
        repeat (300) @(negedge clk);
        rd(R_STAT, v); chk("R10 timeout set", v[4], 1);
        pop(v); chk("R10 byte", v, 8'h33);
        rd(R_STAT, v); chk("R10 timeout cleared", v[4], 0);

        // R8 CTS hold-off
        cts_n = 1;
        wr(R_DATA, 8'h99);
        bad = 0;
        for (int i = 0; i < 600; i++) begin @(negedge clk); if (!txd) bad++; end
        chk("R8 no frame while cts high", bad, 0);
        rd(R_TXCNT, v); chk("R8 byte still queued", v, 1);
        fork
            begin @(negedge clk); cts_n = 0; end
            recv(BIT, 0, "R8 release", d, pb);
        join

        // R13 external clock: 4 clocks per tick, 64 per bit
        wr(R_CTRL, 8'h07);
        ext_run = 1;
        fork
            wr(R_DATA, 8'h6E);
            recv(2*BIT, 0, "R13 ext tx", d, pb);
        join
        send(8'h5C, 0, 0, 1, 2*BIT);
        repeat (8) @(negedge clk);
        pop(v); chk("R13 ext rx byte", v, 8'h5C);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule